// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command interpreter of a byte-wide parallel NOR flash memory model. On a synchronous bus it watches address, write data and three active-low strobes: chip enable, write enable and output enable. A write cycle is any clock edge at which chip enable and write enable are low and output enable is high. The block matches multi-write unlock sequences against that stream. From them it performs byte program, chip erase, a one-time lockout of the boot region, and entry to and exit from an identification mode. It enforces the boot-region protection and the rule that programming can only clear bits.

The storage is a small behavioral register array. Addresses below 0x02000 form the boot region. Boot addresses select the lower half of the array and all others select the upper half. Within each half the cell is chosen by the low `CELL_W` address bits, so addresses alias. Internal timing and busy tracking belong to a separate status block. This block sends that block a one-cycle start pulse carrying the operation kind and the target address, and it takes back a busy level.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every command opens with data 0xAA written to address 0x5555 and then data 0x55 written to 0x2AAA. The third write goes to 0x5555 and carries the command byte. A write that does not fit the next expected step returns the decoder to idle with no effect on the array, the lock or the mode.
- R2: Command byte 0xA0 makes the next write a byte program. The stored byte becomes the old byte ANDed with the written data, so bits only go from 1 to 0.
- R3: Command byte 0x80 must be followed by 0xAA at 0x5555, then 0x55 at 0x2AAA, then a final byte at 0x5555. A final byte of 0x10 sets every cell to 0xFF.
- R4: A final byte of 0x40 in the 0x80 sequence locks the boot region 0x00000 to 0x01FFF until reset. After that, programs aimed at the boot region are dropped with no start pulse, and chip erase leaves the boot cells unchanged.
- R5: Command byte 0x90 enters identification mode. In that mode a read of address 0 returns the manufacturer code (default 0xC7) and a read of address 1 returns the device code (default 0x3B). A read of address 2 returns the lock state on bit 0, where 1 means locked. The mode is left either by the 3-write sequence ending in 0xF0 at 0x5555, or by a single 0xF0 written to any address while the decoder is idle.
- R6: No write cycle takes place while output enable is low, chip enable is high or write enable is high.
- R7: While busy is high, writes are ignored entirely. They neither advance nor reset a sequence, and they raise no start pulse.
- R8: rdData shows the addressed cell while chip enable and output enable are low and write enable is high, and shows 0x00 otherwise. Every cell reads 0xFF after reset.
- R9: The unlock addresses 0x5555 and 0x2AAA are compared on address bits [14:0] only. The array uses all 17 bits.
- R10: startPulse is high for exactly one cycle, in the cycle after the edge that samples the final write of a command. startOp codes are 0 for none, 1 for program, 2 for erase and 3 for lock. On a program pulse, startAddr holds the target address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 17 | Byte address |
| wrData | input | 8 | Write data |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| busy | input | 1 | Status block reports an operation in progress |
| rdData | output | 8 | Read data |
| startPulse | output | 1 | One-cycle start request to the status block |
| startOp | output | 2 | Operation kind of the start request |
| startAddr | output | 17 | Target address of the start request |

## Verification
The hardest situation to reach is the locked boot region under a later erase. It needs the full six-write lockout sequence, an earlier program into a boot cell so that a changed value is visible, and then a second six-write sequence that erases. The stimulus table chains these in that order and reads the boot cell and a main cell afterwards. Unlock sequences with stray high address bits, a broken third write, and writes gated off by each strobe or by busy show that the sequence state was either dropped or left untouched.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_LOCK  = 2'd3
  } opKind_t;

  // Strobes from the sequence control to the datapath
  typedef struct packed {
    logic doProg;
    logic doErase;
    logic doLock;
    logic idEnter;
    logic idExit;
  } cmdStrobe_t;

  localparam logic [14:0] UNLOCK_A = 15'h5555;
  localparam logic [14:0] UNLOCK_B = 15'h2AAA;
  localparam logic [7:0]  KEY_A    = 8'hAA;
  localparam logic [7:0]  KEY_B    = 8'h55;
  localparam logic [7:0]  CMD_PROG = 8'hA0;
  localparam logic [7:0]  CMD_EXT  = 8'h80;
  localparam logic [7:0]  CMD_ID   = 8'h90;
  localparam logic [7:0]  CMD_EXIT = 8'hF0;
  localparam logic [7:0]  SUB_ERASE = 8'h10;
  localparam logic [7:0]  SUB_LOCK  = 8'h40;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic              busy,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output cmdStrobe_t        strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_KEY1, S_KEY2, S_PROG, S_EXT1, S_EXT2, S_EXT3
  } seqState_t;

  seqState_t state, stateNext;
  logic      atA, atB, takeWr;

  assign atA    = (addr[14:0] == UNLOCK_A);   // R9: low 15 bits only
  assign atB    = (addr[14:0] == UNLOCK_B);
  assign takeWr = wrValid && !busy;           // R7

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (takeWr) begin
      stateNext = S_IDLE;                     // R1: default on mismatch
      unique case (state)
        S_IDLE: begin
          if (atA && wrData == KEY_A)  stateNext = S_KEY1;
          else if (wrData == CMD_EXIT) strb.idExit = 1'b1;
        end
        S_KEY1: if (atB && wrData == KEY_B) stateNext = S_KEY2;
        S_KEY2: begin
          if (atA) begin
            unique case (wrData)
              CMD_PROG: stateNext = S_PROG;
              CMD_EXT:  stateNext = S_EXT1;
              CMD_ID:   strb.idEnter = 1'b1;
              CMD_EXIT: strb.idExit  = 1'b1;
              default:  stateNext = S_IDLE;
            endcase
          end
        end
        S_PROG: strb.doProg = 1'b1;
        S_EXT1: if (atA && wrData == KEY_A) stateNext = S_EXT2;
        S_EXT2: if (atB && wrData == KEY_B) stateNext = S_EXT3;
        S_EXT3: begin
          if (atA && wrData == SUB_ERASE) strb.doErase = 1'b1;
          if (atA && wrData == SUB_LOCK)  strb.doLock  = 1'b1;
        end
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R6/R7: without an accepted write the sequence position holds
  p_hold_no_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !takeWr |=> $stable(state));

  // R1: a command strobe always leaves the decoder idle
  p_idle_after_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb != '0) |=> (state == S_IDLE));

endmodule

// File: rtl/flash_array_dp.sv
module flash_array_dp
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W     = 17,
  parameter int          CELL_W     = 4,
  parameter logic [16:0] BOOT_LIMIT = 17'h02000,
  parameter logic [7:0]  MFR_CODE   = 8'hC7,
  parameter logic [7:0]  DEV_CODE   = 8'h3B
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              rdEn,
  output logic [7:0]        rdData,
  output logic              startPulse,
  output opKind_t           startOp,
  output logic [ADDR_W-1:0] startAddr
);

  localparam int HALF  = 2 ** CELL_W;
  localparam int CELLS = 2 * HALF;
  localparam int IDX_W = CELL_W + 1;

  logic [CELLS-1:0][7:0] memQ;
  logic                  locked, idMode;
  logic                  isBoot, progBlocked;
  logic [IDX_W-1:0]      cellIdx;

  assign isBoot      = (ADDR_W'(BOOT_LIMIT) > addr);
  assign cellIdx     = {!isBoot, addr[CELL_W-1:0]};
  assign progBlocked = locked && isBoot;      // R4

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memQ       <= '1;                       // R8: erased state
      locked     <= 1'b0;
      idMode     <= 1'b0;
      startPulse <= 1'b0;
      startOp    <= OP_NONE;
      startAddr  <= '0;
    end else begin
      startPulse <= 1'b0;
      startOp    <= OP_NONE;
      if (strb.doProg && !progBlocked) begin
        memQ[cellIdx] <= memQ[cellIdx] & wrData;   // R2
        startPulse    <= 1'b1;
        startOp       <= OP_PROG;
        startAddr     <= addr;
      end
      if (strb.doErase) begin
        for (int i = 0; i < CELLS; i++) begin
          if (i >= HALF || !locked) memQ[i] <= 8'hFF;  // R3, R4
        end
        startPulse <= 1'b1;
        startOp    <= OP_ERASE;
        startAddr  <= '0;
      end
      if (strb.doLock) begin
        locked     <= 1'b1;
        startPulse <= 1'b1;
        startOp    <= OP_LOCK;
        startAddr  <= '0;
      end
      if (strb.idEnter) idMode <= 1'b1;
      if (strb.idExit)  idMode <= 1'b0;
    end
  end

  always_comb begin
    rdData = 8'h00;
    if (rdEn) begin
      if (idMode) begin                       // R5
        unique case (addr)
          ADDR_W'(0): rdData = MFR_CODE;
          ADDR_W'(1): rdData = DEV_CODE;
          ADDR_W'(2): rdData = {7'b0, locked};
          default:    rdData = 8'h00;
        endcase
      end else begin
        rdData = memQ[cellIdx];
      end
    end
  end

  // R4: lock never clears once set
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

  // R4: boot half frozen while locked
  p_boot_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(memQ[HALF-1:0]));

  // R2: outside erase no bit rises
  p_clear_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doErase |=> ((memQ & ~$past(memQ)) == '0));

  // R10: pulse lasts one cycle and carries a kind
  p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);
  p_pulse_tagged_r10: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (startOp != OP_NONE));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W     = 17,
  parameter int          CELL_W     = 4,
  parameter logic [16:0] BOOT_LIMIT = 17'h02000,
  parameter logic [7:0]  MFR_CODE   = 8'hC7,
  parameter logic [7:0]  DEV_CODE   = 8'h3B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              busy,
  output logic [7:0]        rdData,
  output logic              startPulse,
  output logic [1:0]        startOp,
  output logic [ADDR_W-1:0] startAddr
);

  cmdStrobe_t strb;
  opKind_t    opKind;
  logic       wrValid, rdEn;

  assign wrValid = !ceN && !weN && oeN;       // R6
  assign rdEn    = !ceN && !oeN && weN;       // R8
  assign startOp = opKind;

  flash_seq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .busy(busy),
    .addr(addr), .wrData(wrData), .strb(strb)
  );

  flash_array_dp #(
    .ADDR_W(ADDR_W), .CELL_W(CELL_W), .BOOT_LIMIT(BOOT_LIMIT),
    .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .startPulse(startPulse),
    .startOp(opKind), .startAddr(startAddr)
  );

  // R7: no start request follows a busy cycle
  p_quiet_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !startPulse);

endmodule

// File: tb/sim_flash_cmd_decoder.sv
`timescale 1ns/1ps
module sim_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wrData = '0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1, busy = 1'b0;
  logic [7:0]  rdData;
  logic        startPulse;
  logic [1:0]  startOp;
  logic [16:0] startAddr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  flash_cmd_decoder u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .ceN(ceN),
    .weN(weN), .oeN(oeN), .busy(busy), .rdData(rdData),
    .startPulse(startPulse), .startOp(startOp), .startAddr(startAddr)
  );

  // {req[4], isRead, addr[17], data[8], expect[8], expPulse, expOp[2]}
  localparam int NV = 51;
  localparam logic [40:0] VEC [NV] = '{
    {4'd8, 1'b1, 17'h00003, 8'h00, 8'hFF, 1'b0, 2'd0},  // R8 erased
    {4'd2, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h05555, 8'hA0, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h02001, 8'h0F, 8'h00, 1'b1, 2'd1},
    {4'd2, 1'b1, 17'h02001, 8'h00, 8'h0F, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h05555, 8'hA0, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h02001, 8'hF3, 8'h00, 1'b1, 2'd1},
    {4'd2, 1'b1, 17'h02001, 8'h00, 8'h03, 1'b0, 2'd0},  // R2 AND
    {4'd2, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h05555, 8'hA0, 8'h00, 1'b0, 2'd0},
    {4'd2, 1'b0, 17'h00004, 8'h5A, 8'h00, 1'b1, 2'd1},
    {4'd2, 1'b1, 17'h00004, 8'h00, 8'h5A, 1'b0, 2'd0},
    {4'd1, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},  // R1 broken
    {4'd1, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd1, 1'b0, 17'h04444, 8'hA0, 8'h00, 1'b0, 2'd0},
    {4'd1, 1'b0, 17'h02002, 8'h77, 8'h00, 1'b0, 2'd0},
    {4'd1, 1'b1, 17'h02002, 8'h00, 8'hFF, 1'b0, 2'd0},
    {4'd9, 1'b0, 17'h1D555, 8'hAA, 8'h00, 1'b0, 2'd0},  // R9 high bits
    {4'd9, 1'b0, 17'h0AAAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd9, 1'b0, 17'h1D555, 8'hA0, 8'h00, 1'b0, 2'd0},
    {4'd9, 1'b0, 17'h02005, 8'h3C, 8'h00, 1'b1, 2'd1},
    {4'd9, 1'b1, 17'h02005, 8'h00, 8'h3C, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},  // R4 lockout
    {4'd4, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h05555, 8'h80, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h05555, 8'h40, 8'h00, 1'b1, 2'd3},
    {4'd4, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h05555, 8'hA0, 8'h00, 1'b0, 2'd0},
    {4'd4, 1'b0, 17'h00004, 8'h00, 8'h00, 1'b0, 2'd0},  // dropped
    {4'd4, 1'b1, 17'h00004, 8'h00, 8'h5A, 1'b0, 2'd0},
    {4'd5, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},  // R5 id entry
    {4'd5, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd5, 1'b0, 17'h05555, 8'h90, 8'h00, 1'b0, 2'd0},
    {4'd5, 1'b1, 17'h00002, 8'h00, 8'h01, 1'b0, 2'd0},
    {4'd5, 1'b1, 17'h00000, 8'h00, 8'hC7, 1'b0, 2'd0},
    {4'd5, 1'b1, 17'h00001, 8'h00, 8'h3B, 1'b0, 2'd0},
    {4'd5, 1'b0, 17'h12345, 8'hF0, 8'h00, 1'b0, 2'd0},  // single exit
    {4'd5, 1'b1, 17'h00002, 8'h00, 8'hFF, 1'b0, 2'd0},
    {4'd3, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},  // R3 erase
    {4'd3, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd3, 1'b0, 17'h05555, 8'h80, 8'h00, 1'b0, 2'd0},
    {4'd3, 1'b0, 17'h05555, 8'hAA, 8'h00, 1'b0, 2'd0},
    {4'd3, 1'b0, 17'h02AAA, 8'h55, 8'h00, 1'b0, 2'd0},
    {4'd3, 1'b0, 17'h05555, 8'h10, 8'h00, 1'b1, 2'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busOp(input logic [16:0] a, input logic [7:0] d,
                       input logic c, input logic w, input logic o);
    @(negedge clk);
    addr = a; wrData = d; ceN = c; weN = w; oeN = o;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    busOp(a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic rd(input logic [16:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    #1 v = rdData;
    ceN = 1'b1; oeN = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10 and R8 reset state
    chk("R10 reset pulse", startPulse, 0);
    chk("R10 reset op", startOp, 0);
    chk("R8 idle output", rdData, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d step %0d", VEC[i][40:37], i);
      if (VEC[i][36]) begin
        rd(VEC[i][35:19], v);
        chk(tag, v, VEC[i][10:3]);
      end else begin
        wr(VEC[i][35:19], VEC[i][18:11]);
        chk({tag, " pulse"}, startPulse, VEC[i][2]);
        chk({tag, " op"}, startOp, VEC[i][1:0]);
        if (VEC[i][2] && VEC[i][1:0] == 2'd1)
          chk({tag, " addr"}, startAddr, VEC[i][35:19]);
      end
    end

    // R3/R4: after erase main cells are erased, locked boot cell kept
    rd(17'h02001, v); chk("R3 main erased", v, 8'hFF);
    rd(17'h02005, v); chk("R3 main erased b", v, 8'hFF);
    rd(17'h00004, v); chk("R4 boot kept", v, 8'h5A);

    // R5: three-write exit
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h90);
    rd(17'h00002, v); chk("R5 lock bit", v, 8'h01);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
    rd(17'h00002, v); chk("R5 three-write exit", v, 8'hFF);

    // R6: first unlock write gated by each strobe in turn
    busOp(17'h05555, 8'hAA, 1'b1, 1'b0, 1'b1);  // chip enable high
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h02003, 8'h11);
    chk("R6 ce high pulse", startPulse, 0);
    rd(17'h02003, v); chk("R6 ce high", v, 8'hFF);
    busOp(17'h05555, 8'hAA, 1'b0, 1'b0, 1'b0);  // output enable low
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h02003, 8'h12);
    rd(17'h02003, v); chk("R6 oe low", v, 8'hFF);
    busOp(17'h05555, 8'hAA, 1'b0, 1'b1, 1'b1);  // write enable high
    wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0); wr(17'h02003, 8'h13);
    rd(17'h02003, v); chk("R6 we high", v, 8'hFF);

    // R7: whole sequence under busy is ignored
    busy = 1'b1;
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    wr(17'h02006, 8'h00);
    chk("R7 busy pulse", startPulse, 0);
    busy = 1'b0;
    rd(17'h02006, v); chk("R7 busy no write", v, 8'hFF);
    // R7: busy freezes a started sequence rather than resetting it
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    busy = 1'b1; wr(17'h02007, 8'hFF); busy = 1'b0;
    wr(17'h02007, 8'h81);
    chk("R7 resume pulse", startPulse, 1);
    rd(17'h02007, v); chk("R7 resumed program", v, 8'h81);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule